// File: doc/BRIEF.md
# Vectored Prioritized Interrupt Controller

This block gathers sixteen interrupt channels into a single vectored request for a processor. The channels are held in two byte-wide banks: bank A holds channels 15 down to 8 and bank B holds channels 7 down to 0. Eight of the channels are driven by transitions on an eight-pin general-purpose port. Each pin has a direction bit and a polarity bit that decide whether it is watched and which edge counts. The other eight channels take single-cycle event strobes from neighbouring timer and serial logic.

Each channel passes through several stages in turn. It must be enabled for an event to be latched as pending. It must be unmasked for the pending bit to be offered to the processor. A fixed priority then picks the winner, and channel 15 ranks highest. The processor answers with an acknowledge strobe and reads an eight-bit vector made of a programmable upper nibble and the winning channel number. In the automatic end-of-interrupt mode, acknowledge only retires the pending bit. In the software mode, acknowledge also marks the channel in service. Equal and lower channels then stay held off until software clears that in-service bit.

Top module: `irq_vec_top`

## Requirements
- R1: After reset every register reads zero, `irqReq` is low, `vecOut` is 8'h00 and `gpioOe` is 8'h00.
- R2: Register selects are: 0 pin polarity, 1 pin direction, 2 enable A, 3 enable B, 4 pending A, 5 pending B, 6 in-service A, 7 in-service B, 8 mask A, 9 mask B, 10 vector. Bit i of a bank A register is channel 8+i, and bit i of a bank B register is channel i. Unused selects read 0.
- R3: Pin bits 0..7 map to channels 0,1,2,3,6,7,14,15. An input pin whose polarity bit is 1 latches its channel pending on a 0-to-1 transition. When its polarity bit is 0, it latches on a 1-to-0 transition.
- R4: A pin whose direction bit is 1 is an output. Its bit on `gpioOe` is high, and transitions on it latch nothing.
- R5: An `evtIn` pulse on a channel that no pin serves sets that channel pending only while its enable bit is 1. `evtIn` bits of pin-served channels are ignored. Clearing an enable bit also clears that channel's pending bit.
- R6: A mask bit of 1 lets a pending channel request. A mask bit of 0 blocks the request but leaves the pending bit set.
- R7: `vecOut` is {vector[7:4], number of the highest requesting channel} while `irqReq` is high, and 8'h00 otherwise.
- R8: An `ackStb` while `irqReq` is high clears the pending bit of the channel in `vecOut`. With vector bit 3 at 0, the in-service registers stay zero.
- R9: With vector bit 3 at 1, acknowledge sets the channel's in-service bit. While any in-service bit is set, only channels numbered strictly above the highest in-service channel may raise `irqReq`.
- R10: Writing a pending or in-service register clears the bits written 0 and leaves the bits written 1 unchanged.
- R11: An `ackStb` while `irqReq` is low changes no pending or in-service bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| gpioIn | input | 8 | General-purpose pin levels, synchronous to clk |
| gpioOe | output | 8 | Direction bits (1 = pin driven as output) |
| evtIn | input | 16 | Per-channel event strobes from timer and serial logic |
| regWr | input | 1 | Register write strobe |
| regSel | input | 4 | Register select |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data of the selected register |
| ackStb | input | 1 | Processor acknowledge strobe |
| irqReq | output | 1 | Interrupt request to the processor |
| vecOut | output | 8 | Vector returned for the current request |

## Verification
The edge path is driven with both polarities and with a pin switched to output. This separates a polarity mix-up or a missing direction gate from a correct edge detector. The request path is driven with two pending channels at once, with a masked-but-pending channel, and with an acknowledge while idle. These show whether priority, masking and pending clearing act on the right bit. The in-service path runs a lower, an equal and a higher channel against a set in-service bit. Partial write-0 clears on it then expose off-by-one comparisons and write polarity faults.

// File: rtl/irq_pkg.sv
package irq_pkg;

  typedef enum logic [3:0] {
    SEL_EDGE   = 4'd0,
    SEL_DIR    = 4'd1,
    SEL_EN_A   = 4'd2,
    SEL_EN_B   = 4'd3,
    SEL_PEND_A = 4'd4,
    SEL_PEND_B = 4'd5,
    SEL_INSV_A = 4'd6,
    SEL_INSV_B = 4'd7,
    SEL_MASK_A = 4'd8,
    SEL_MASK_B = 4'd9,
    SEL_VEC    = 4'd10
  } regSel_e;

  typedef struct packed {
    logic wrEdge;
    logic wrDir;
    logic wrEnA;
    logic wrEnB;
    logic wrPendA;
    logic wrPendB;
    logic wrInsvA;
    logic wrInsvB;
    logic wrMaskA;
    logic wrMaskB;
    logic wrVec;
    logic ackTake;
  } ctrlStb_t;

endpackage

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int N = 16,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = |req;
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_pkg::*;
(
  input  logic       regWr,
  input  logic [3:0] regSel,
  input  logic       ackStb,
  input  logic       irqReq,
  output ctrlStb_t   stb
);
  always_comb begin
    stb = '0;
    stb.ackTake = ackStb && irqReq;
    if (regWr) begin
      case (regSel)
        SEL_EDGE:   stb.wrEdge  = 1'b1;
        SEL_DIR:    stb.wrDir   = 1'b1;
        SEL_EN_A:   stb.wrEnA   = 1'b1;
        SEL_EN_B:   stb.wrEnB   = 1'b1;
        SEL_PEND_A: stb.wrPendA = 1'b1;
        SEL_PEND_B: stb.wrPendB = 1'b1;
        SEL_INSV_A: stb.wrInsvA = 1'b1;
        SEL_INSV_B: stb.wrInsvB = 1'b1;
        SEL_MASK_A: stb.wrMaskA = 1'b1;
        SEL_MASK_B: stb.wrMaskB = 1'b1;
        SEL_VEC:    stb.wrVec   = 1'b1;
        default:    ;
      endcase
    end
  end
endmodule

// File: rtl/irq_datapath.sv
module irq_datapath
  import irq_pkg::*;
#(
  parameter int BANK_W = 8,
  parameter int GPIO_W = 8,
  parameter int VEC_W  = 8,
  parameter logic [GPIO_W*$clog2(2*BANK_W)-1:0] GPIO_MAP = 32'hFE76_3210,
  localparam int NUM_CH = 2 * BANK_W,
  localparam int CH_W   = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStb_t          stb,
  input  logic [GPIO_W-1:0] gpioIn,
  input  logic [NUM_CH-1:0] evtIn,
  input  logic [3:0]        regSel,
  input  logic [BANK_W-1:0] regWrData,
  output logic [BANK_W-1:0] regRdData,
  output logic [GPIO_W-1:0] gpioOe,
  output logic              irqReq,
  output logic [VEC_W-1:0]  vecOut,
  output logic [NUM_CH-1:0] pendAll,
  output logic [NUM_CH-1:0] insvAll,
  output logic [NUM_CH-1:0] maskAll,
  output logic [NUM_CH-1:0] setAll,
  output logic              swEoi
);
  localparam int VHI_W = VEC_W - CH_W;

  logic [GPIO_W-1:0] edgeReg, dirReg, gpioPrev;
  logic              primed;
  logic [NUM_CH-1:0] enReg, pendReg, insvReg, maskReg;
  logic [VEC_W-1:0]  vecReg;

  logic [GPIO_W-1:0] edgeHit;
  logic [NUM_CH-1:0] pinSet, pinChans, setRaw;
  logic [NUM_CH-1:0] enNext, pendKeep, insvKeep, ackHot, pendNext, insvNext;
  logic              actAny, insAny;
  logic [CH_W-1:0]   actIdx, insIdx;

  // transition detection on input pins
  always_comb begin
    for (int g = 0; g < GPIO_W; g++) begin
      edgeHit[g] = primed && !dirReg[g] &&
                   (edgeReg[g] ? (gpioIn[g] && !gpioPrev[g])
                               : (!gpioIn[g] && gpioPrev[g]));
    end
  end

  // pin to channel routing
  always_comb begin
    pinSet   = '0;
    pinChans = '0;
    for (int g = 0; g < GPIO_W; g++) begin
      pinChans[GPIO_MAP[g*CH_W +: CH_W]] = 1'b1;
      if (edgeHit[g]) pinSet[GPIO_MAP[g*CH_W +: CH_W]] = 1'b1;
    end
    setRaw = (pinSet | (evtIn & ~pinChans)) & enReg;
  end

  // priority selection
  irq_prio_enc #(.N(NUM_CH)) i_actEnc (
    .req (pendReg & maskReg),
    .any (actAny),
    .idx (actIdx)
  );

  irq_prio_enc #(.N(NUM_CH)) i_insEnc (
    .req (insvReg),
    .any (insAny),
    .idx (insIdx)
  );

  assign swEoi  = vecReg[VHI_W > 0 ? VEC_W - VHI_W - 1 : 0];
  assign irqReq = actAny && (!insAny || (actIdx > insIdx));
  assign vecOut = irqReq ? {vecReg[VEC_W-1 -: VHI_W], actIdx} : '0;

  // next-state of the channel registers
  always_comb begin
    enNext   = enReg;
    pendKeep = '1;
    insvKeep = '1;
    if (stb.wrEnA)   enNext[NUM_CH-1:BANK_W]   = regWrData;
    if (stb.wrEnB)   enNext[BANK_W-1:0]        = regWrData;
    if (stb.wrPendA) pendKeep[NUM_CH-1:BANK_W] = regWrData;
    if (stb.wrPendB) pendKeep[BANK_W-1:0]      = regWrData;
    if (stb.wrInsvA) insvKeep[NUM_CH-1:BANK_W] = regWrData;
    if (stb.wrInsvB) insvKeep[BANK_W-1:0]      = regWrData;
    ackHot = '0;
    if (stb.ackTake) ackHot[actIdx] = 1'b1;
    pendNext = ((pendReg & pendKeep & ~ackHot) | setRaw) & enNext;
    insvNext = (insvReg & insvKeep) | (swEoi ? ackHot : '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      edgeReg  <= '0;
      dirReg   <= '0;
      gpioPrev <= '0;
      primed   <= 1'b0;
      enReg    <= '0;
      pendReg  <= '0;
      insvReg  <= '0;
      maskReg  <= '0;
      vecReg   <= '0;
    end else begin
      primed   <= 1'b1;
      gpioPrev <= gpioIn;
      if (stb.wrEdge)  edgeReg <= regWrData[GPIO_W-1:0];
      if (stb.wrDir)   dirReg  <= regWrData[GPIO_W-1:0];
      if (stb.wrMaskA) maskReg[NUM_CH-1:BANK_W] <= regWrData;
      if (stb.wrMaskB) maskReg[BANK_W-1:0]      <= regWrData;
      if (stb.wrVec)   vecReg  <= regWrData[VEC_W-1:0];
      enReg   <= enNext;
      pendReg <= pendNext;
      insvReg <= insvNext;
    end
  end

  // register read mux
  always_comb begin
    regRdData = '0;
    case (regSel)
      SEL_EDGE:   regRdData[GPIO_W-1:0] = edgeReg;
      SEL_DIR:    regRdData[GPIO_W-1:0] = dirReg;
      SEL_EN_A:   regRdData = enReg[NUM_CH-1:BANK_W];
      SEL_EN_B:   regRdData = enReg[BANK_W-1:0];
      SEL_PEND_A: regRdData = pendReg[NUM_CH-1:BANK_W];
      SEL_PEND_B: regRdData = pendReg[BANK_W-1:0];
      SEL_INSV_A: regRdData = insvReg[NUM_CH-1:BANK_W];
      SEL_INSV_B: regRdData = insvReg[BANK_W-1:0];
      SEL_MASK_A: regRdData = maskReg[NUM_CH-1:BANK_W];
      SEL_MASK_B: regRdData = maskReg[BANK_W-1:0];
      SEL_VEC:    regRdData[VEC_W-1:0] = vecReg;
      default:    ;
    endcase
  end

  assign gpioOe  = dirReg;
  assign pendAll = pendReg;
  assign insvAll = insvReg;
  assign maskAll = maskReg;
  assign setAll  = setRaw;
endmodule

// File: rtl/irq_vec_top.sv
module irq_vec_top
  import irq_pkg::*;
#(
  parameter int BANK_W = 8,
  parameter int GPIO_W = 8,
  parameter int VEC_W  = 8,
  parameter logic [GPIO_W*$clog2(2*BANK_W)-1:0] GPIO_MAP = 32'hFE76_3210,
  localparam int NUM_CH = 2 * BANK_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [GPIO_W-1:0] gpioIn,
  output logic [GPIO_W-1:0] gpioOe,
  input  logic [NUM_CH-1:0] evtIn,
  input  logic              regWr,
  input  logic [3:0]        regSel,
  input  logic [BANK_W-1:0] regWrData,
  output logic [BANK_W-1:0] regRdData,
  input  logic              ackStb,
  output logic              irqReq,
  output logic [VEC_W-1:0]  vecOut
);
  ctrlStb_t          stb;
  logic [NUM_CH-1:0] pendAll, insvAll, maskAll, setAll;
  logic              swEoi;

  irq_ctrl i_ctrl (
    .regWr  (regWr),
    .regSel (regSel),
    .ackStb (ackStb),
    .irqReq (irqReq),
    .stb    (stb)
  );

  irq_datapath #(
    .BANK_W   (BANK_W),
    .GPIO_W   (GPIO_W),
    .VEC_W    (VEC_W),
    .GPIO_MAP (GPIO_MAP)
  ) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .gpioIn    (gpioIn),
    .evtIn     (evtIn),
    .regSel    (regSel),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .gpioOe    (gpioOe),
    .irqReq    (irqReq),
    .vecOut    (vecOut),
    .pendAll   (pendAll),
    .insvAll   (insvAll),
    .maskAll   (maskAll),
    .setAll    (setAll),
    .swEoi     (swEoi)
  );
endmodule

// File: rtl/irq_vec_chk.sv
module irq_vec_chk #(
  parameter int NUM_CH = 16,
  parameter int VEC_W  = 8,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input logic              clk,
  input logic              rstN,
  input logic              ackStb,
  input logic              irqReq,
  input logic [VEC_W-1:0]  vecOut,
  input logic [NUM_CH-1:0] pendAll,
  input logic [NUM_CH-1:0] insvAll,
  input logic [NUM_CH-1:0] maskAll,
  input logic [NUM_CH-1:0] setAll,
  input logic              swEoi
);
  logic [CH_W-1:0] lastCh;
  logic [NUM_CH-1:0] lastSet;
  logic [CH_W-1:0] topInsv;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastCh  <= '0;
      lastSet <= '0;
    end else begin
      lastCh  <= vecOut[CH_W-1:0];
      lastSet <= setAll;
    end
  end

  always_comb begin
    topInsv = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (insvAll[i] && topInsv == '0) topInsv = CH_W'(i);
    end
  end

  // R6: a request always has an unmasked pending channel behind it
  p_req_needs_pend_r6: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> (|(pendAll & maskAll)));

  // R8: acknowledge retires the pending bit unless a new event re-set it
  p_ack_clears_r8: assert property (@(posedge clk) disable iff (!rstN)
    (ackStb && irqReq) |=> (!pendAll[lastCh] || lastSet[lastCh]));

  // R8: automatic mode never sets an in-service bit
  p_auto_no_insv_r8: assert property (@(posedge clk) disable iff (!rstN)
    (ackStb && irqReq && !swEoi && insvAll == '0) |=> (insvAll == '0));

  // R9: software mode marks the acknowledged channel in service
  p_sw_sets_insv_r9: assert property (@(posedge clk) disable iff (!rstN)
    (ackStb && irqReq && swEoi) |=> insvAll[lastCh]);

  // R9: a request during service comes from a strictly higher channel
  p_higher_only_r9: assert property (@(posedge clk) disable iff (!rstN)
    (irqReq && insvAll != '0) |-> (vecOut[CH_W-1:0] > topInsv));
endmodule

bind irq_vec_top irq_vec_chk #(.NUM_CH(NUM_CH), .VEC_W(VEC_W)) i_chk (
  .clk     (clk),
  .rstN    (rstN),
  .ackStb  (ackStb),
  .irqReq  (irqReq),
  .vecOut  (vecOut),
  .pendAll (pendAll),
  .insvAll (insvAll),
  .maskAll (maskAll),
  .setAll  (setAll),
  .swEoi   (swEoi)
);

// File: tb/test_irq_vec_top.sv
`timescale 1ns/1ps
module test_irq_vec_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  gpioIn = '0;
  logic [7:0]  gpioOe;
  logic [15:0] evtIn = '0;
  logic        regWr = 1'b0;
  logic [3:0]  regSel = '0;
  logic [7:0]  regWrData = '0;
  logic [7:0]  regRdData;
  logic        ackStb = 1'b0;
  logic        irqReq;
  logic [7:0]  vecOut;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  localparam logic [3:0] S_EDGE = 4'd0, S_DIR = 4'd1, S_ENA = 4'd2, S_ENB = 4'd3,
    S_PNA = 4'd4, S_PNB = 4'd5, S_ISA = 4'd6, S_ISB = 4'd7, S_MKA = 4'd8,
    S_MKB = 4'd9, S_VEC = 4'd10;

  always #10 clk = ~clk;  // 50 MHz

  irq_vec_top i_irq_vec_top (
    .clk(clk), .rstN(rstN), .gpioIn(gpioIn), .gpioOe(gpioOe), .evtIn(evtIn),
    .regWr(regWr), .regSel(regSel), .regWrData(regWrData), .regRdData(regRdData),
    .ackStb(ackStb), .irqReq(irqReq), .vecOut(vecOut)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wrReg(logic [3:0] sel, logic [7:0] data);
    @(negedge clk);
    regWr = 1'b1; regSel = sel; regWrData = data;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rdReg(logic [3:0] sel, output logic [7:0] data);
    regSel = sel;
    #1 data = regRdData;
  endtask

  task automatic chkReg(string req, logic [3:0] sel, logic [7:0] exp);
    logic [7:0] d;
    rdReg(sel, d);
    check(req, d, exp);
  endtask

  task automatic pulse(logic [15:0] bits);
    @(negedge clk);
    evtIn = bits;
    @(negedge clk);
    evtIn = '0;
  endtask

  task automatic setPin(int idx, logic val);
    @(negedge clk);
    gpioIn[idx] = val;
    @(negedge clk);
  endtask

  task automatic doAck(output logic [7:0] v);
    @(negedge clk);
    ackStb = 1'b1;
    #1 v = vecOut;
    @(negedge clk);
    ackStb = 1'b0;
  endtask

  task automatic t_reset;
    for (int s = 0; s < 11; s++) chkReg("R1", 4'(s), 8'h00);
    check("R1 irqReq", {7'd0, irqReq}, 8'h00);
    check("R1 vecOut", vecOut, 8'h00);
    check("R1 gpioOe", gpioOe, 8'h00);
  endtask

  task automatic t_gpio;
    wrReg(S_ENA, 8'hFF); wrReg(S_ENB, 8'hFF);
    wrReg(S_MKA, 8'hFF); wrReg(S_MKB, 8'hFF);
    wrReg(S_VEC, 8'h40);
    wrReg(S_EDGE, 8'h41);
    chkReg("R2 edge readback", S_EDGE, 8'h41);
    setPin(0, 1'b1);
    chkReg("R3 rising pin0", S_PNB, 8'h01);
    check("R7 vec ch0", vecOut, 8'h40);
    setPin(1, 1'b1);
    chkReg("R3 rising ignored on falling pin", S_PNB, 8'h01);
    setPin(1, 1'b0);
    chkReg("R3 falling pin1", S_PNB, 8'h03);
    check("R7 vec ch1", vecOut, 8'h41);
    setPin(6, 1'b1);
    chkReg("R3 pin6 to ch14", S_PNA, 8'h40);
    check("R7 vec ch14", vecOut, 8'h4E);
    wrReg(S_PNA, 8'h00); wrReg(S_PNB, 8'h00);
    check("R7 idle vec", vecOut, 8'h00);
  endtask

  task automatic t_dir;
    wrReg(S_DIR, 8'h04);
    check("R4 gpioOe", gpioOe, 8'h04);
    setPin(2, 1'b1);
    setPin(2, 1'b0);
    chkReg("R4 output pin ignored", S_PNB, 8'h00);
    wrReg(S_DIR, 8'h00);
  endtask

  task automatic t_event;
    wrReg(S_ENB, 8'hEF);
    pulse(16'h0010);
    chkReg("R5 disabled event", S_PNB, 8'h00);
    wrReg(S_ENB, 8'hFF);
    pulse(16'h0010);
    chkReg("R5 enabled event", S_PNB, 8'h10);
    pulse(16'h0001);
    chkReg("R5 pin channel strobe ignored", S_PNB, 8'h10);
    wrReg(S_ENB, 8'hEF);
    chkReg("R5 disable clears pending", S_PNB, 8'h00);
    wrReg(S_ENB, 8'hFF);
  endtask

  task automatic t_mask;
    logic [7:0] v;
    wrReg(S_MKA, 8'hFD);
    pulse(16'h0200);
    chkReg("R6 masked stays pending", S_PNA, 8'h02);
    check("R6 masked no req", {7'd0, irqReq}, 8'h00);
    doAck(v);
    chkReg("R11 idle ack pending kept", S_PNA, 8'h02);
    chkReg("R11 idle ack insv", S_ISA, 8'h00);
    wrReg(S_MKA, 8'hFF);
    check("R6 unmasked req", {7'd0, irqReq}, 8'h01);
    check("R7 vec ch9", vecOut, 8'h49);
    wrReg(S_PNA, 8'h00);
  endtask

  task automatic t_prio;
    logic [7:0] v;
    wrReg(S_VEC, 8'hA0);
    pulse(16'h1020);
    check("R7 highest wins", vecOut, 8'hAC);
    doAck(v);
    check("R8 ack vector", v, 8'hAC);
    chkReg("R8 pending cleared", S_PNA, 8'h00);
    chkReg("R8 auto insv A", S_ISA, 8'h00);
    check("R7 next vec", vecOut, 8'hA5);
    doAck(v);
    check("R8 second ack", v, 8'hA5);
    chkReg("R8 auto insv B", S_ISB, 8'h00);
    check("R8 idle after acks", {7'd0, irqReq}, 8'h00);
  endtask

  task automatic t_sweoi;
    logic [7:0] v;
    wrReg(S_VEC, 8'hA8);
    pulse(16'h0400);
    doAck(v);
    check("R9 ack ch10", v, 8'hAA);
    chkReg("R9 insv set", S_ISA, 8'h04);
    pulse(16'h0020);
    check("R9 lower held", {7'd0, irqReq}, 8'h00);
    pulse(16'h0400);
    check("R9 equal held", {7'd0, irqReq}, 8'h00);
    pulse(16'h2000);
    check("R9 higher passes", vecOut, 8'hAD);
    doAck(v);
    chkReg("R9 nested insv", S_ISA, 8'h24);
    wrReg(S_PNA, 8'hFF);
    chkReg("R10 pending write 1 keeps", S_PNA, 8'h04);
    wrReg(S_ISA, 8'hDF);
    chkReg("R10 insv write 0 clears", S_ISA, 8'h04);
    check("R9 still held", {7'd0, irqReq}, 8'h00);
    wrReg(S_ISA, 8'h00);
    check("R9 released", vecOut, 8'hAA);
    doAck(v);
    check("R9 ch5 below insv", {7'd0, irqReq}, 8'h00);
    wrReg(S_ISA, 8'h00);
    check("R9 ch5 after release", vecOut, 8'hA5);
    wrReg(S_PNB, 8'hDF);
    chkReg("R10 pending write 0 clears", S_PNB, 8'h00);
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    t_gpio;
    t_dir;
    t_event;
    t_mask;
    t_prio;
    t_sweoi;
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule